// File: doc/BRIEF.md
# Zero-Cross Gated Volume and Phase Stage

This block sits between a sample source and a set of DAC channels. It scales six 24-bit signed audio lanes, arranged as three stereo pairs, by a per-lane attenuation code. It can also invert the output of any pair. All six lanes arrive together with one valid strobe. The scaled and inverted results leave one cycle later with their own valid flag.

Volume codes are written one lane at a time. A written code first goes into a per-lane pending slot. When zero-cross gating is active, the pending code takes effect only on a sample where that lane's waveform passes through zero, so a gain step does not cause an audible click. Gating is active when the disable input is low. When gating is turned off, a pending code takes effect on the very next valid sample.

Top module: `zcvol_top`

## Requirements
- R1: `outValid` rises exactly one clock after a cycle with `sampleValid` high and is low otherwise. `sampleOut` keeps its value through cycles without `sampleValid`.
- R2: Lane `c` occupies bits `24c+23:24c` of the sample buses. For a code `v` from 1 to 255, let `k = 255 - v`. The gain is `G = B[k mod 12] >> floor(k/12)`, where B = 65536, 61870, 58409, 55142, 52057, 49144, 46396, 43801, 41350, 39037, 36854, 34792. The output is `(x*G + 32768) >>> 16`, saturated to the signed 24-bit range.
- R3: Code 0 mutes the lane, so the output is 0.
- R4: A write with `volWrEn` high stores `volWrCode` as the pending code of lane `volWrChan`. Lane numbers run 0 to 5: lane `c` belongs to pair `c/2`, and even lanes are left. Writes to lane numbers 6 and 7 change nothing.
- R5: While `zcDisable` is 0, a lane's pending code is applied on its first valid sample that is either exactly zero or has a sign bit different from that lane's previous valid sample. That sample is already scaled with the new code.
- R6: While `zcDisable` is 1, every pending code is applied on the next valid sample, and that sample uses it.
- R7: A crossing on one lane never applies the pending code of another lane.
- R8: When `phaseInvert[p]` is 1 on a valid sample, both lanes of pair `p` are output negated. A result of -8388608 is output as 8388607 instead.
- R9: After reset, `outValid` and `sampleOut` are 0. Every lane starts at code 255 with nothing pending. Every lane's previous sign is treated as non-negative.
- R10: If a write to a lane arrives in the same cycle as that lane's commit, the sample uses the older pending code, and the newly written code stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | All six input lanes carry a new sample |
| sampleIn | input | 144 | Six packed signed 24-bit samples |
| volWrEn | input | 1 | Volume write strobe |
| volWrChan | input | 3 | Lane addressed by the write |
| volWrCode | input | 8 | Attenuation code to store as pending |
| zcDisable | input | 1 | 1 bypasses zero-cross gating |
| phaseInvert | input | 3 | One invert bit per stereo pair |
| outValid | output | 1 | Output lanes were updated |
| sampleOut | output | 144 | Six packed scaled signed 24-bit samples |

## Verification
The checker tests the following on every cycle:
- the output valid timing,
- that outputs hold between samples,
- that a zero input gives a zero output,
- that the most negative value never appears on an inverted pair,
- that pending flags clear on a valid sample when gating is bypassed,
- that pending flags stay put when there is no write and no sample.

Only the bench scenarios can show the following, because each depends on stored per-lane history:
- the actual gain values,
- that a code waits for a sign change or a zero sample,
- that lanes do not disturb one another,
- that writes to lane numbers 6 and 7 are ignored,
- the outcome when a write collides with a commit.

// File: rtl/zcvol_pkg.sv
package zcvol_pkg;
  localparam int NUM_PAIRS = 3;
  localparam int NUM_LANES = 2 * NUM_PAIRS;
  localparam int SAMPLE_W  = 24;
  localparam int CODE_W    = 8;
  localparam int GAIN_W    = 17;
  localparam int FRAC_W    = 16;
  localparam int CHAN_W    = $clog2(NUM_LANES + 2);
  localparam logic [CODE_W-1:0] UNITY_CODE = '1;

  typedef struct packed {
    logic                 advance;
    logic [NUM_LANES-1:0] commit;
  } zcStrobe_t;

  // Attenuation code to Q1.16 gain: 0.5 dB steps, 12 steps per octave shift.
  function automatic logic [GAIN_W-1:0] codeToGain(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] steps;
    logic [CODE_W-1:0] frac;
    logic [CODE_W-1:0] octave;
    logic [GAIN_W-1:0] base;
    steps  = UNITY_CODE - code;
    frac   = steps % CODE_W'(12);
    octave = steps / CODE_W'(12);
    case (frac)
      8'd0:    base = 17'd65536;
      8'd1:    base = 17'd61870;
      8'd2:    base = 17'd58409;
      8'd3:    base = 17'd55142;
      8'd4:    base = 17'd52057;
      8'd5:    base = 17'd49144;
      8'd6:    base = 17'd46396;
      8'd7:    base = 17'd43801;
      8'd8:    base = 17'd41350;
      8'd9:    base = 17'd39037;
      8'd10:   base = 17'd36854;
      default: base = 17'd34792;
    endcase
    if (code == '0) codeToGain = '0;
    else            codeToGain = base >> octave;
  endfunction
endpackage

// File: rtl/zcvol_ctrl.sv
module zcvol_ctrl
  import zcvol_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sampleValid,
  input  logic [NUM_LANES*SAMPLE_W-1:0] sampleIn,
  input  logic                          volWrEn,
  input  logic [CHAN_W-1:0]             volWrChan,
  input  logic [CODE_W-1:0]             volWrCode,
  input  logic                          zcDisable,
  output zcStrobe_t                     strobes,
  output logic [NUM_LANES*CODE_W-1:0]   pendCode,
  output logic [NUM_LANES-1:0]          pendFlag
);
  logic [NUM_LANES-1:0] prevNeg;
  logic [NUM_LANES-1:0] crossing;
  logic [NUM_LANES-1:0] commitNow;

  assign strobes.advance = sampleValid;
  assign strobes.commit  = commitNow;

  for (genvar c = 0; c < NUM_LANES; c++) begin : g_lane
    logic [SAMPLE_W-1:0] laneSample;
    logic                laneNeg;
    logic                wrHit;

    assign laneSample   = sampleIn[c*SAMPLE_W +: SAMPLE_W];
    assign laneNeg      = laneSample[SAMPLE_W-1];
    assign crossing[c]  = (laneSample == '0) || (laneNeg != prevNeg[c]);
    assign commitNow[c] = sampleValid && pendFlag[c] && (zcDisable || crossing[c]);
    assign wrHit        = volWrEn && (volWrChan == CHAN_W'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prevNeg[c]                      <= 1'b0;
        pendFlag[c]                     <= 1'b0;
        pendCode[c*CODE_W +: CODE_W]    <= UNITY_CODE;
      end else begin
        if (sampleValid) prevNeg[c] <= laneNeg;
        if (wrHit) begin
          pendCode[c*CODE_W +: CODE_W] <= volWrCode;
          pendFlag[c]                  <= 1'b1;
        end else if (commitNow[c]) begin
          pendFlag[c] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/zcvol_scale.sv
module zcvol_scale
  import zcvol_pkg::*;
(
  input  logic signed [SAMPLE_W-1:0] laneIn,
  input  logic        [GAIN_W-1:0]   gain,
  input  logic                       invert,
  output logic signed [SAMPLE_W-1:0] laneOut
);
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] MAX_V =
    {{(PROD_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] MIN_V =
    {{(PROD_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};
  localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [SAMPLE_W-1:0] OUT_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SAMPLE_W-1:0] OUT_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [PROD_W-1:0]   product;
  logic signed [PROD_W-1:0]   rounded;
  logic signed [SAMPLE_W-1:0] clipped;

  always_comb begin
    product = PROD_W'(laneIn) * $signed({1'b0, gain});
    rounded = (product + HALF_LSB) >>> FRAC_W;
    if (rounded > MAX_V)      clipped = OUT_MAX;
    else if (rounded < MIN_V) clipped = OUT_MIN;
    else                      clipped = rounded[SAMPLE_W-1:0];
    if (!invert)              laneOut = clipped;
    else if (clipped == OUT_MIN) laneOut = OUT_MAX;
    else                      laneOut = -clipped;
  end
endmodule

// File: rtl/zcvol_dp.sv
module zcvol_dp
  import zcvol_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  zcStrobe_t                     strobes,
  input  logic [NUM_LANES*SAMPLE_W-1:0] sampleIn,
  input  logic [NUM_LANES*CODE_W-1:0]   pendCode,
  input  logic [NUM_PAIRS-1:0]          phaseInvert,
  output logic                          outValid,
  output logic [NUM_LANES*SAMPLE_W-1:0] sampleOut
);
  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= strobes.advance;
  end

  for (genvar c = 0; c < NUM_LANES; c++) begin : g_lane
    logic [CODE_W-1:0]          activeCode;
    logic [CODE_W-1:0]          useCode;
    logic signed [SAMPLE_W-1:0] scaled;

    assign useCode = strobes.commit[c] ? pendCode[c*CODE_W +: CODE_W] : activeCode;

    zcvol_scale u_scale (
      .laneIn  (sampleIn[c*SAMPLE_W +: SAMPLE_W]),
      .gain    (codeToGain(useCode)),
      .invert  (phaseInvert[c/2]),
      .laneOut (scaled)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        activeCode                         <= UNITY_CODE;
        sampleOut[c*SAMPLE_W +: SAMPLE_W]  <= '0;
      end else if (strobes.advance) begin
        activeCode                         <= useCode;
        sampleOut[c*SAMPLE_W +: SAMPLE_W]  <= scaled;
      end
    end
  end
endmodule

// File: rtl/zcvol_top.sv
module zcvol_top
  import zcvol_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sampleValid,
  input  logic [NUM_LANES*SAMPLE_W-1:0] sampleIn,
  input  logic                          volWrEn,
  input  logic [CHAN_W-1:0]             volWrChan,
  input  logic [CODE_W-1:0]             volWrCode,
  input  logic                          zcDisable,
  input  logic [NUM_PAIRS-1:0]          phaseInvert,
  output logic                          outValid,
  output logic [NUM_LANES*SAMPLE_W-1:0] sampleOut
);
  zcStrobe_t                     strobes;
  logic [NUM_LANES*CODE_W-1:0]   pendCode;
  logic [NUM_LANES-1:0]          pendFlag;

  zcvol_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sampleValid (sampleValid),
    .sampleIn    (sampleIn),
    .volWrEn     (volWrEn),
    .volWrChan   (volWrChan),
    .volWrCode   (volWrCode),
    .zcDisable   (zcDisable),
    .strobes     (strobes),
    .pendCode    (pendCode),
    .pendFlag    (pendFlag)
  );

  zcvol_dp u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .sampleIn    (sampleIn),
    .pendCode    (pendCode),
    .phaseInvert (phaseInvert),
    .outValid    (outValid),
    .sampleOut   (sampleOut)
  );
endmodule

// File: rtl/zcvol_checks.sv
module zcvol_checks
  import zcvol_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          sampleValid,
  input logic [NUM_LANES*SAMPLE_W-1:0] sampleIn,
  input logic                          volWrEn,
  input logic                          zcDisable,
  input logic [NUM_PAIRS-1:0]          phaseInvert,
  input logic                          outValid,
  input logic [NUM_LANES*SAMPLE_W-1:0] sampleOut,
  input logic [NUM_LANES-1:0]          pendFlag
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |=> outValid);
  a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |=> !outValid);
  a_r1_output_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |=> $stable(sampleOut));
  a_r6_pending_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && zcDisable && !volWrEn) |=> (pendFlag == '0));
  a_r5_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampleValid && !volWrEn) |=> $stable(pendFlag));

  for (genvar c = 0; c < NUM_LANES; c++) begin : g_lane
    a_r3_zero_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sampleValid && sampleIn[c*SAMPLE_W +: SAMPLE_W] == '0)
        |=> (sampleOut[c*SAMPLE_W +: SAMPLE_W] == '0));
    a_r8_no_min_inverted: assert property (@(posedge clk) disable iff (!rst_n)
      (sampleValid && phaseInvert[c/2])
        |=> (sampleOut[c*SAMPLE_W +: SAMPLE_W] != {1'b1, {(SAMPLE_W-1){1'b0}}}));
  end
endmodule

bind zcvol_top zcvol_checks chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sampleValid (sampleValid),
  .sampleIn    (sampleIn),
  .volWrEn     (volWrEn),
  .zcDisable   (zcDisable),
  .phaseInvert (phaseInvert),
  .outValid    (outValid),
  .sampleOut   (sampleOut),
  .pendFlag    (pendFlag)
);

// File: tb/zcvol_top_test.sv
`timescale 1ns/1ps
module zcvol_top_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sampleValid = 1'b0;
  logic [143:0] sampleIn = '0;
  logic         volWrEn = 1'b0;
  logic [2:0]   volWrChan = '0;
  logic [7:0]   volWrCode = '0;
  logic         zcDisable = 1'b0;
  logic [2:0]   phaseInvert = '0;
  logic         outValid;
  logic [143:0] sampleOut;

  int checks = 0;
  int errors = 0;
  string req = "R9";
  int baseTab [12] = '{65536, 61870, 58409, 55142, 52057, 49144,
                       46396, 43801, 41350, 39037, 36854, 34792};
  int  mCur [6];
  int  mPend [6];
  bit  mFlag [6];
  bit  mNeg [6];
  logic [143:0] expOut = '0;
  bit  expValid = 1'b0;

  always #2.5 clk = ~clk;

  zcvol_top uut (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .volWrEn(volWrEn), .volWrChan(volWrChan), .volWrCode(volWrCode),
    .zcDisable(zcDisable), .phaseInvert(phaseInvert),
    .outValid(outValid), .sampleOut(sampleOut)
  );

  function automatic longint gainOf(int code);
    int k;
    if (code == 0) return 0;
    k = 255 - code;
    return longint'(baseTab[k % 12] >> (k / 12));
  endfunction

  function automatic longint scaleRef(longint x, longint g, bit inv);
    longint r;
    r = (x * g + 32768) >>> 16;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    if (inv) r = (r == -8388608) ? 8388607 : -r;
    return r;
  endfunction

  task automatic compare();
    checks++;
    if (outValid !== expValid || sampleOut !== expOut) begin
      errors++;
      $display("FAIL %s: outValid=%0b sampleOut=%h expected outValid=%0b sampleOut=%h",
               req, outValid, sampleOut, expValid, expOut);
    end
  endtask

  task automatic tick();
    for (int c = 0; c < 6; c++) begin
      longint x;
      bit commit;
      int useCode;
      x = longint'($signed(sampleIn[c*24 +: 24]));
      commit = sampleValid && mFlag[c] && (zcDisable || x == 0 || ((x < 0) != mNeg[c]));
      useCode = commit ? mPend[c] : mCur[c];
      if (sampleValid) begin
        longint y;
        y = scaleRef(x, gainOf(useCode), phaseInvert[c/2]);
        expOut[c*24 +: 24] = y[23:0];
        mNeg[c] = (x < 0);
      end
      if (commit) mCur[c] = mPend[c];
      if (volWrEn && volWrChan == 3'(c)) begin
        mPend[c] = int'(volWrCode);
        mFlag[c] = 1'b1;
      end else if (commit) begin
        mFlag[c] = 1'b0;
      end
    end
    expValid = sampleValid;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic setLanes(int a, int b, int c, int d, int e, int f);
    sampleIn = {f[23:0], e[23:0], d[23:0], c[23:0], b[23:0], a[23:0]};
  endtask

  task automatic push(int a, int b, int c, int d, int e, int f);
    setLanes(a, b, c, d, e, f);
    sampleValid = 1'b1;
    tick();
    sampleValid = 1'b0;
  endtask

  task automatic wr(int ch, int code);
    volWrEn = 1'b1;
    volWrChan = 3'(ch);
    volWrCode = 8'(code);
    tick();
    volWrEn = 1'b0;
  endtask

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    for (int c = 0; c < 6; c++) begin
      mCur[c] = 255; mPend[c] = 255; mFlag[c] = 0; mNeg[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state and unity default gain
    req = "R9";
    compare();
    tick();
    push(1000, -1000, 8388607, -8388608, 12345, 0);

    // R2: unity gain over several patterns
    req = "R2";
    push(-1, 1, 4194304, -4194305, 77, -77);

    // R6: gating bypassed, codes land on the next valid sample
    req = "R6";
    zcDisable = 1'b1;
    wr(0, 254); wr(1, 243); wr(2, 231); wr(3, 200); wr(4, 1); wr(5, 128);
    push(1000000, 1000000, 1000000, 1000000, 8388607, -8388608);
    req = "R2";
    push(-3, 3, -8388608, 8388607, -5000000, 2);

    // R3: mute
    req = "R3";
    wr(2, 0);
    push(5, 5, 8388607, -8388608, 5, 5);

    // R5: gating active, hold until sign change or zero
    req = "R5";
    zcDisable = 1'b0;
    push(500, 500, 500, 500, 500, 500);
    wr(0, 240);
    wr(1, 230);
    push(600, 600, 600, 600, 600, 600);
    push(700, 700, 700, 700, 700, 700);
    push(-700, 0, 700, 700, 700, 700);
    push(-800, 800, 800, 800, 800, 800);

    // R7: crossing on one lane leaves other lanes pending
    req = "R7";
    wr(2, 100);
    wr(3, 150);
    push(-900, 900, 900, -900, 900, 900);
    push(-900, 900, 900, -900, 900, 900);
    push(-900, 900, -900, -900, 900, 900);

    // R8: pair inversion and most-negative handling
    req = "R8";
    zcDisable = 1'b1;
    wr(0, 255); wr(1, 255);
    phaseInvert = 3'b101;
    push(-8388608, -8388608, 123, -123, 8388607, -8388608);
    push(0, 42, -42, 42, -1, 1);
    phaseInvert = 3'b000;

    // R4: writes to lane numbers 6 and 7 do nothing
    req = "R4";
    wr(6, 10);
    wr(7, 10);
    push(40000, 40000, 40000, 40000, 40000, 40000);
    wr(5, 180);
    push(40000, 40000, 40000, 40000, 40000, 40000);

    // R10: write colliding with a commit
    req = "R10";
    wr(0, 200);
    volWrEn = 1'b1; volWrChan = 3'd0; volWrCode = 8'd50;
    push(300000, 300000, 300000, 300000, 300000, 300000);
    volWrEn = 1'b0;
    push(300000, 300000, 300000, 300000, 300000, 300000);

    // R1: idle cycles hold output and valid drops
    req = "R1";
    setLanes(1, 2, 3, 4, 5, 6);
    tick();
    setLanes(-9, -9, -9, -9, -9, -9);
    tick();
    push(11, 22, 33, 44, 55, 66);
    tick();

    // R2: pseudo-random mixed traffic
    req = "R2";
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      zcDisable = lfsr[5] & lfsr[9];
      phaseInvert = lfsr[14:12];
      volWrEn = lfsr[3] & lfsr[7];
      volWrChan = lfsr[18:16];
      volWrCode = lfsr[27:20];
      sampleValid = lfsr[2] | lfsr[11];
      sampleIn = {lfsr, lfsr ^ 32'h5A5A_A5A5, ~lfsr, lfsr ^ 32'hFFFF0000,
                  {lfsr[15:0], lfsr[31:16]}};
      tick();
    end
    sampleValid = 1'b0;
    volWrEn = 1'b0;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule